// File: doc/BRIEF.md
# Multi-format asynchronous serial transceiver

This block is a full-duplex asynchronous serial port. Both directions run from a shared strobe that pulses sixteen times per bit period. One format input selects a frame of 7, 8 or 9 data bits, with an optional parity bit for the 7-bit and 8-bit widths. A second input selects even or odd parity. Frames start with a low start bit, carry data least significant bit first, and end with one high stop bit. The line idles high.

The receiver confirms each start bit at its midpoint and samples every later bit at its center. It then moves the word into a holding register. The transfer point depends on the frame length. When a frame carries nine data-or-parity slots, the word is handed over at the center of the ninth slot, one bit period before the stop bit. Shorter frames hand it over at the center of the stop bit. The receive event strobe and the overrun and parity flags follow that transfer point. The stop-bit check always waits for the stop bit's center, so after an early handover it becomes valid one bit period after the event.

The transmitter takes words through a valid/ready handshake. It can hold one queued word while the stop bit of the current frame is on the line. It pulses its event strobe in the last clock before the stop bit is driven.

Top module: `uart_mf`

## Requirements
- R1: After reset, tx_line is high, tx_ready is high, and rx_avail, err_stop, err_par, err_ovr, rx_evt and tx_evt are all low.
- R2: frame_fmt selects the frame. Code 0 is 7 data bits. Code 1 is 7 data bits plus parity. Code 2 is 8 data bits. Code 3 is 8 data bits plus parity. Code 4 is 9 data bits. Codes 5 to 7 behave as code 2. A frame is one low start bit, the data least significant bit first, the parity bit (if any), then one high stop bit. Received data bits above the data width read as zero.
- R3: With odd_par low, the parity bit makes the number of ones across data and parity even. With odd_par high, it makes that number odd.
- R4: tx_evt is high for exactly the last clock of the final data or parity bit, and tx_line is at the stop level in the next clock.
- R5: tx_ready is high only when no word is queued and the transmitter is idle or sending a stop bit. A word accepted during a stop bit starts its start bit within two clocks after that stop bit's sixteen ticks end.
- R6: A start bit is accepted only if the line is still low half a bit period after the falling edge. A shorter low pulse produces no frame. Each later bit is taken at the center of its period.
- R7: With 9 slots between start and stop (codes 3 and 4), rx_evt pulses for one clock at the center of the ninth slot. Otherwise it pulses at the center of the stop bit. rx_word takes the new data and rx_avail rises on the same clock edge as rx_evt.
- R8: err_stop is updated at the center of the stop bit in every format, set when that bit is low and cleared when it is high. After an early event it is therefore valid one bit period later.
- R9: err_par is updated at the transfer point. For code 3 that is the center of the parity bit, for code 1 the center of the stop bit. It is set when the received parity disagrees with R3 and is always clear for formats without parity.
- R10: At each transfer point err_ovr is set if rx_avail is still high and rx_ack is not asserted, and is cleared otherwise. The new word replaces the old one in either case.
- R11: A one-clock pulse on rx_ack clears rx_avail and leaves rx_word unchanged.
- R12: One bit period is sixteen ovs_tick pulses in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovs_tick | input | 1 | Oversampling strobe, sixteen per bit period |
| frame_fmt | input | 3 | Frame format code |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even |
| tx_data | input | 9 | Word to transmit, upper bits unused for shorter formats |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter accepts a word this clock |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_word | output | 9 | Last received word |
| rx_ack | input | 1 | Read acknowledge for rx_word |
| rx_avail | output | 1 | rx_word holds unread data |
| err_stop | output | 1 | Last stop bit was low |
| err_par | output | 1 | Parity mismatch on the last word |
| err_ovr | output | 1 | Last word arrived while rx_avail was still set |
| rx_evt | output | 1 | Receive event strobe |
| tx_evt | output | 1 | Transmit event strobe |

## Verification
The hardest case to reach from the ports is a 9-slot frame whose stop bit is bad. Reaching it requires the event and the stop check to disagree inside the same frame. The bench drives a deliberately low stop bit after a clean frame and snapshots err_stop at the rx_evt clock, where it must still be clear, then reads it again after the stop bit's center, where it must be set. Center sampling is tested by driving data bits that show the wrong level near both edges of each bit period. Overrun is tested by leaving one word unacknowledged across a second full frame.

// File: rtl/uart_mf_pkg.sv
package uart_mf_pkg;

  localparam int unsigned WORD_W = 9;

  typedef enum logic [2:0] {
    FMT_D7  = 3'd0,
    FMT_D7P = 3'd1,
    FMT_D8  = 3'd2,
    FMT_D8P = 3'd3,
    FMT_D9  = 3'd4
  } fmt_e;

  // number of data bits carried by a format code
  function automatic logic [3:0] data_bits(input logic [2:0] f);
    case (f)
      FMT_D7, FMT_D7P: data_bits = 4'd7;
      FMT_D9:          data_bits = 4'd9;
      default:         data_bits = 4'd8;
    endcase
  endfunction

  function automatic logic has_par(input logic [2:0] f);
    has_par = (f == FMT_D7P) || (f == FMT_D8P);
  endfunction

  // slots between start and stop: data plus optional parity
  function automatic logic [3:0] slot_count(input logic [2:0] f);
    slot_count = data_bits(f) + {3'd0, has_par(f)};
  endfunction

  // word handed over before the stop bit when nine slots precede it
  function automatic logic early_xfer(input logic [2:0] f);
    early_xfer = (slot_count(f) == 4'd9);
  endfunction

  // parity bit value for the first nd bits of d
  function automatic logic par_bit(input logic [WORD_W-1:0] d,
                                   input logic [3:0] nd,
                                   input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (i < int'(nd)) p = p ^ d[i];
    end
    par_bit = p;
  endfunction

endpackage

// File: rtl/uart_mf_sync.sv
module uart_mf_sync #(
  parameter int STAGES  = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= IDLE_LVL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= {STAGES{IDLE_LVL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uart_mf_rx.sv
module uart_mf_rx
  import uart_mf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        fmt,
  input  logic              odd,
  input  logic              rx_in,
  input  logic              ack,
  output logic [WORD_W-1:0] word,
  output logic              avail,
  output logic              err_stop,
  output logic              err_par,
  output logic              err_ovr,
  output logic              evt
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_SLOT, R_STOP} rx_st_e;

  rx_st_e            st;
  logic [CW-1:0]     cnt;
  logic [3:0]        idx;
  logic [WORD_W-1:0] dbuf, dnext, data_now;
  logic              pbit, pnext, par_now;
  logic [2:0]        fmt_q;
  logic [3:0]        nd, nslots;
  logic              tick_last;

  // named internal events
  logic ev_slot, ev_last_slot, ev_stop, ev_xfer;

  assign nd           = data_bits(fmt_q);
  assign nslots       = slot_count(fmt_q);
  assign tick_last    = tick && (cnt == LAST);
  assign ev_slot      = (st == R_SLOT) && tick_last;
  assign ev_last_slot = ev_slot && (idx == nslots - 4'd1);
  assign ev_stop      = (st == R_STOP) && tick_last;
  assign ev_xfer      = early_xfer(fmt_q) ? ev_last_slot : ev_stop;

  always_comb begin
    dnext = dbuf;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if ((idx == 4'(i)) && (idx < nd)) dnext[i] = rx_in;
    end
    pnext    = (idx == nd) ? rx_in : pbit;
    data_now = (st == R_SLOT) ? dnext : dbuf;
    par_now  = (st == R_SLOT) ? pnext : pbit;
  end

  // bit-level state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= R_IDLE;
      cnt   <= '0;
      idx   <= '0;
      dbuf  <= '0;
      pbit  <= 1'b0;
      fmt_q <= FMT_D8;
    end else begin
      case (st)
        R_IDLE: begin
          if (tick && !rx_in) begin
            st  <= R_START;
            cnt <= '0;
          end
        end
        R_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_in) begin
                st    <= R_SLOT;
                idx   <= '0;
                dbuf  <= '0;
                pbit  <= 1'b0;
                fmt_q <= fmt;
              end else begin
                st <= R_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        R_SLOT: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt  <= '0;
              dbuf <= dnext;
              pbit <= pnext;
              if (ev_last_slot) st <= R_STOP;
              else              idx <= idx + 4'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt <= '0;
              st  <= R_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // holding register and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word     <= '0;
      avail    <= 1'b0;
      err_stop <= 1'b0;
      err_par  <= 1'b0;
      err_ovr  <= 1'b0;
      evt      <= 1'b0;
    end else begin
      evt <= ev_xfer;
      if (ev_xfer) begin
        word    <= data_now;
        avail   <= 1'b1;
        err_ovr <= avail && !ack;
        err_par <= has_par(fmt_q) && (par_now != par_bit(data_now, nd, odd));
      end else if (ack) begin
        avail <= 1'b0;
      end
      if (ev_stop) err_stop <= !rx_in;
    end
  end

  a_r7_evt_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  a_r7_avail_rises_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail) |-> evt);
  a_r10_ovr_rises_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> evt);
  a_r8_stop_flag_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_stop |=> $stable(err_stop));
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ev_xfer) |=> !avail);
endmodule

// File: rtl/uart_mf_tx.sv
module uart_mf_tx
  import uart_mf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        fmt,
  input  logic              odd,
  input  logic [WORD_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line,
  output logic              evt
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {T_IDLE, T_START, T_SLOT, T_STOP} tx_st_e;

  tx_st_e            st;
  logic [CW-1:0]     cnt;
  logic [3:0]        idx;
  logic [WORD_W-1:0] shd, pend_d;
  logic              pend_v;
  logic              tpar;
  logic [2:0]        tfmt;
  logic [3:0]        nd, nslots;
  logic              slot_bit;
  logic              accept;

  assign nd     = data_bits(tfmt);
  assign nslots = slot_count(tfmt);
  assign ready  = !pend_v && ((st == T_IDLE) || (st == T_STOP));
  assign accept = valid && ready;
  assign evt    = (st == T_SLOT) && tick && (cnt == LAST) && (idx == nslots - 4'd1);

  always_comb begin
    slot_bit = tpar;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if ((idx == 4'(i)) && (idx < nd)) slot_bit = shd[i];
    end
    case (st)
      T_START: line = 1'b0;
      T_SLOT:  line = slot_bit;
      default: line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shd    <= '0;
      tpar   <= 1'b0;
      tfmt   <= FMT_D8;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      if (accept) begin
        pend_v <= 1'b1;
        pend_d <= data;
      end
      case (st)
        T_IDLE: begin
          if (pend_v) begin
            st     <= T_START;
            cnt    <= '0;
            shd    <= pend_d;
            tfmt   <= fmt;
            tpar   <= par_bit(pend_d, data_bits(fmt), odd);
            pend_v <= 1'b0;
          end
        end
        T_START: begin
          if (tick) begin
            if (cnt == LAST) begin
              st  <= T_SLOT;
              cnt <= '0;
              idx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        T_SLOT: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (evt) st <= T_STOP;
              else     idx <= idx + 4'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (cnt == LAST) begin
              st  <= T_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  a_r4_stop_after_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> line);
  a_r4_evt_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  a_r5_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/uart_mf.sv
module uart_mf
  import uart_mf_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovs_tick,
  input  logic [2:0]        frame_fmt,
  input  logic              odd_par,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [WORD_W-1:0] rx_word,
  input  logic              rx_ack,
  output logic              rx_avail,
  output logic              err_stop,
  output logic              err_par,
  output logic              err_ovr,
  output logic              rx_evt,
  output logic              tx_evt
);
  logic rx_s;

  uart_mf_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (rx_s)
  );

  uart_mf_rx #(.OVS(OVS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ovs_tick),
    .fmt      (frame_fmt),
    .odd      (odd_par),
    .rx_in    (rx_s),
    .ack      (rx_ack),
    .word     (rx_word),
    .avail    (rx_avail),
    .err_stop (err_stop),
    .err_par  (err_par),
    .err_ovr  (err_ovr),
    .evt      (rx_evt)
  );

  uart_mf_tx #(.OVS(OVS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ovs_tick),
    .fmt   (frame_fmt),
    .odd   (odd_par),
    .data  (tx_data),
    .valid (tx_valid),
    .ready (tx_ready),
    .line  (tx_line),
    .evt   (tx_evt)
  );
endmodule

// File: tb/uart_mf_test.sv
module uart_mf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovs_tick = 1'b1;
  logic [2:0] frame_fmt = 3'd2;
  logic       odd_par = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line;
  logic       rx_line = 1'b1;
  logic [8:0] rx_word;
  logic       rx_ack = 1'b0;
  logic       rx_avail, err_stop, err_par, err_ovr, rx_evt, tx_evt;

  always #5 clk = ~clk;

  uart_mf uut (
    .clk(clk), .rst_n(rst_n), .ovs_tick(ovs_tick), .frame_fmt(frame_fmt),
    .odd_par(odd_par), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line), .rx_line(rx_line), .rx_word(rx_word), .rx_ack(rx_ack),
    .rx_avail(rx_avail), .err_stop(err_stop), .err_par(err_par), .err_ovr(err_ovr),
    .rx_evt(rx_evt), .tx_evt(tx_evt)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int evt_cnt = 0;
  int evt_cyc = 0;
  logic snap_fe, snap_pe, snap_ov;
  logic [8:0] snap_d;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rx_evt) begin
      evt_cnt = evt_cnt + 1;
      evt_cyc = cyc;
      snap_fe = err_stop;
      snap_pe = err_par;
      snap_ov = err_ovr;
      snap_d  = rx_word;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int b_nd(input logic [2:0] f);
    if (f <= 3'd1) return 7;
    if (f == 3'd4) return 9;
    return 8;
  endfunction

  function automatic int b_hp(input logic [2:0] f);
    return (f == 3'd1 || f == 3'd3) ? 1 : 0;
  endfunction

  function automatic logic [8:0] b_mask(input int nd);
    return 9'((1 << nd) - 1);
  endfunction

  // parity from a ones count: even parity bit equals count mod 2
  function automatic logic b_par(input logic [8:0] d, input int nd, input logic odd);
    int ones;
    ones = $countones(d & b_mask(nd));
    return logic'(ones % 2) ^ odd;
  endfunction

  function automatic logic [11:0] b_frame(input logic [2:0] f, input logic [8:0] d,
                                          input logic odd, input logic flip, input logic stopv);
    logic [11:0] fb;
    int nd, hp;
    nd = b_nd(f); hp = b_hp(f);
    fb = '0;
    for (int k = 0; k < nd; k++) fb[1+k] = d[k];
    if (hp == 1) fb[1+nd] = b_par(d, nd, odd) ^ flip;
    fb[nd+hp+1] = stopv;
    return fb;
  endfunction

  task automatic pulse_ack();
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  task automatic drive_rx(input logic [2:0] f, input logic [8:0] d, input logic odd,
                          input logic flip, input logic stopv, input logic smear,
                          output int st);
    logic [11:0] fb;
    int nb;
    fb = b_frame(f, d, odd, flip, stopv);
    nb = b_nd(f) + b_hp(f) + 2;
    frame_fmt = f;
    odd_par = odd;
    st = cyc;
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < 16; c++) begin
        if (smear && b > 0 && b < nb - 1 && (c < 3 || c > 13)) rx_line = ~fb[b];
        else rx_line = fb[b];
        @(negedge clk);
      end
    end
    rx_line = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_line == 1'b1, "R1 tx_line idle", tx_line, 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk({rx_avail, err_stop, err_par, err_ovr, rx_evt, tx_evt} == 6'b0,
        "R1 flags clear", {rx_avail, err_stop, err_par, err_ovr, rx_evt, tx_evt}, 0);
  endtask

  task automatic send_tx(input logic [2:0] f, input logic [8:0] d, input logic odd);
    int w;
    frame_fmt = f;
    odd_par = odd;
    w = 0;
    while (!tx_ready && w < 400) begin @(negedge clk); w++; end
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic cap_tx(input logic [2:0] f, input logic [8:0] d, input logic odd);
    logic [11:0] bits, fb;
    int ns, nb, irq_at, w;
    logic rdy_mid;
    ns = b_nd(f) + b_hp(f);
    nb = ns + 2;
    bits = '0;
    irq_at = -1;
    rdy_mid = 1'b1;
    w = 0;
    while (tx_line !== 1'b0 && w < 64) begin @(negedge clk); w++; end
    for (int c = 0; c < 16 * nb; c++) begin
      if (c % 16 == 8) bits[c/16] = tx_line;
      if (tx_evt && irq_at < 0) irq_at = c;
      if (c == 40) rdy_mid = tx_ready;
      @(negedge clk);
    end
    fb = b_frame(f, d, odd, 1'b0, 1'b1);
    chk(bits == fb, "R2 R12 transmitted frame", bits, fb);
    if (b_hp(f) == 1)
      chk(bits[1+b_nd(f)] == b_par(d, b_nd(f), odd), "R3 transmitted parity",
          bits[1+b_nd(f)], b_par(d, b_nd(f), odd));
    chk(irq_at == 16 * (ns + 1) - 1, "R4 tx_evt before stop", irq_at, 16 * (ns + 1) - 1);
    chk(rdy_mid == 1'b0, "R5 not ready mid frame", rdy_mid, 0);
  endtask

  task automatic t_tx(input logic [2:0] f, input logic [8:0] d, input logic odd);
    send_tx(f, d, odd);
    cap_tx(f, d, odd);
  endtask

  task automatic t_tx_b2b();
    int w, gap;
    send_tx(3'd2, 9'h0A5, 1'b0);
    w = 0;
    while (!tx_evt && w < 400) begin @(negedge clk); w++; end
    @(negedge clk);
    chk(tx_ready == 1'b1, "R5 ready during stop bit", tx_ready, 1);
    tx_data = 9'h03C;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R5 not ready with word queued", tx_ready, 0);
    gap = 2;
    while (tx_line !== 1'b0 && gap < 60) begin @(negedge clk); gap++; end
    chk(gap >= 17 && gap <= 18, "R5 queued start follows stop", gap, 18);
    cap_tx(3'd2, 9'h03C, 1'b0);
  endtask

  task automatic t_rx(input logic [2:0] f, input logic [8:0] d, input logic odd,
                      input logic flip, input logic stopv, input logic smear);
    int c0, st, ns, bi, dl;
    logic fe0;
    logic [8:0] dm;
    ns = b_nd(f) + b_hp(f);
    c0 = evt_cnt;
    fe0 = err_stop;
    drive_rx(f, d, odd, flip, stopv, smear, st);
    chk(evt_cnt == c0 + 1, "R7 R6 one receive event", evt_cnt - c0, 1);
    bi = (ns == 9) ? 9 : ns + 1;
    dl = evt_cyc - st;
    chk(dl >= 16 * bi + 8 && dl <= 16 * bi + 14, "R7 R12 event at sample point", dl, 16 * bi + 11);
    dm = d & b_mask(b_nd(f));
    chk(snap_d == dm, "R2 R6 received word", snap_d, dm);
    chk(snap_pe == ((b_hp(f) == 1) && flip), "R9 parity flag at event", snap_pe,
        (b_hp(f) == 1) && flip);
    chk(snap_fe == ((ns == 9) ? fe0 : !stopv), "R8 stop flag at event", snap_fe,
        (ns == 9) ? fe0 : !stopv);
    chk(err_stop == !stopv, "R8 stop flag after stop center", err_stop, !stopv);
    chk(snap_ov == 1'b0, "R10 no overrun when read", snap_ov, 0);
    chk(rx_avail == 1'b1, "R7 avail set", rx_avail, 1);
    pulse_ack();
    chk(rx_avail == 1'b0, "R11 ack clears avail", rx_avail, 0);
    chk(rx_word == dm, "R11 word kept after ack", rx_word, dm);
  endtask

  task automatic t_glitch();
    int c0;
    c0 = evt_cnt;
    frame_fmt = 3'd2;
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk(evt_cnt == c0, "R6 short low pulse ignored", evt_cnt - c0, 0);
    chk(rx_avail == 1'b0, "R6 no word from glitch", rx_avail, 0);
  endtask

  task automatic t_overrun();
    int st;
    drive_rx(3'd2, 9'h011, 1'b0, 1'b0, 1'b1, 1'b0, st);
    drive_rx(3'd2, 9'h0E2, 1'b0, 1'b0, 1'b1, 1'b0, st);
    chk(snap_ov == 1'b1, "R10 overrun at event", snap_ov, 1);
    chk(rx_word == 9'h0E2, "R10 new word overwrites", rx_word, 9'h0E2);
    pulse_ack();
    drive_rx(3'd2, 9'h05A, 1'b0, 1'b0, 1'b1, 1'b0, st);
    chk(snap_ov == 1'b0, "R10 overrun cleared on next frame", snap_ov, 0);
    pulse_ack();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx(3'd0, 9'h155, 1'b0);
    t_tx(3'd1, 9'h06B, 1'b0);
    t_tx(3'd2, 9'h0C3, 1'b1);
    t_tx(3'd3, 9'h0B7, 1'b1);
    t_tx(3'd3, 9'h0B6, 1'b0);
    t_tx(3'd4, 9'h1A9, 1'b0);
    t_tx(3'd6, 9'h181, 1'b0);
    t_tx_b2b();
    t_rx(3'd0, 9'h05A, 1'b0, 1'b0, 1'b1, 1'b0);
    t_rx(3'd1, 9'h033, 1'b1, 1'b0, 1'b1, 1'b0);
    t_rx(3'd2, 9'h0A7, 1'b0, 1'b0, 1'b1, 1'b0);
    t_rx(3'd3, 9'h0F1, 1'b0, 1'b0, 1'b1, 1'b0);
    t_rx(3'd4, 9'h1C5, 1'b0, 1'b0, 1'b1, 1'b0);
    t_rx(3'd3, 9'h04E, 1'b0, 1'b1, 1'b1, 1'b0);
    t_rx(3'd1, 9'h04E, 1'b1, 1'b1, 1'b1, 1'b0);
    t_rx(3'd4, 9'h0F0, 1'b0, 1'b0, 1'b0, 1'b0);
    t_rx(3'd4, 9'h10F, 1'b0, 1'b0, 1'b1, 1'b0);
    t_rx(3'd2, 9'h099, 1'b0, 1'b0, 1'b0, 1'b0);
    t_rx(3'd2, 9'h0B4, 1'b0, 1'b0, 1'b1, 1'b1);
    t_rx(3'd4, 9'h15A, 1'b0, 1'b0, 1'b1, 1'b1);
    t_glitch();
    t_overrun();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R1 actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule